// File: doc/BRIEF.md
# GPIO Pad Event Interrupt Controller

A bank of general-purpose pads with one configuration word per pad. Each pad's input is synchronized, optionally blocked by a receiver-disable bit, optionally inverted, and then turned into an event. The event kind is picked per pad: active level, single rising edge, both edges, or none. Inversion turns these into falling-edge and active-low detection. Each event sets a sticky interrupt status bit and a sticky wake status bit. Both are write-one-to-clear. Separate enable words gate them onto one combined interrupt line and one wake line.

Pads are grouped into words of `GROUP_SIZE` bits for the status and enable registers. The last group may be partial. The same configuration word also carries the value driven on the pad, an output-disable bit and a mode field; the pad's output driver is on only in GPIO mode. A plain register bus reaches everything. Reads are combinational while `bus_re` is high, and writes take effect at the clock edge where `bus_we` is high.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset:
  - every status and enable bit is 0;
  - `irq_o` and `wake_o` are 0;
  - each configuration word reads 0x0400_0100 (event detection off, output driver off).
- R2: Bits 26:25 of a configuration word select detection on the conditioned input: 0 active level, 1 rising edge, 2 none, 3 both edges. Bit 23 inverts the received input before detection.
- R3: The pad input passes two synchronizer flops. A change driven before clock edge k shows as a set status bit after edge k+2. Configuration bit 1 reads the received input after synchronization. Setting bit 9 forces the received input to 0.
- R4: `pad_out` follows configuration bit 0. `pad_oe` is 1 only when bit 8 is 0 and the mode field in bits 13:10 is 0.
- R5: Interrupt status for pad p is bit p%GROUP_SIZE of the word at 0x100 + 4*(p/GROUP_SIZE). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: In level mode the status bit is set again on every cycle the level is active, so a clear does not stick while the level is active. A set and a clear in the same cycle leave the bit set.
- R7: Interrupt enable words sit at 0x120 + 4*group with the same bit layout. `irq_o` rises one clock after any pad has both its status bit and its enable bit set.
- R8: When no enabled status bit is set, `irq_o` is 0 in the following cycle, for example one clock after the enables are cleared.
- R9: Bits of the last group that map to no pad always read 0, in every status and enable word, even after a write of all ones.
- R10: Wake status at 0x140 + 4*group is set by the same events and is write-one-to-clear. Wake enable sits at 0x160 + 4*group. `wake_o` is 1 one clock after a pad has wake status and wake enable set while its configuration bit 19 (SCI route) is 0.
- R11: The configuration word of pad p is at address 8*p. Only bits 0, 8 to 13, 17 to 20, 23, 25 and 26 are stored; all other bits read 0, except bit 1, which reads the input state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; gates bus_rdata |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | NUM_PADS | Pad inputs, asynchronous |
| pad_out | output | NUM_PADS | Value driven on each pad |
| pad_oe | output | NUM_PADS | Output driver enable for each pad |
| irq_o | output | 1 | Combined registered interrupt |
| wake_o | output | 1 | Combined registered wake request |

## Verification
A vector table drives pad 0 through every detection code, with and without inversion, and with the input low-to-high, high-to-low and steady. The status is read twice: once after the transition and once after a clear. The first read separates edge from level detection. The second separates a sticky edge capture from a level that keeps re-setting the bit. Directed cases then cover:
- the exact cycle of the status and interrupt updates;
- receiver disable;
- the partial last group;
- writes of zero to status words;
- wake suppression by the SCI route bit;
- output drive and mode gating.

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl #(
  parameter int NUM_PADS   = 12,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam logic [ADDR_W-1:0] ISTS_BASE = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] IEN_BASE  = ADDR_W'(12'h120);
  localparam logic [ADDR_W-1:0] WSTS_BASE = ADDR_W'(12'h140);
  localparam logic [ADDR_W-1:0] WEN_BASE  = ADDR_W'(12'h160);
  localparam logic [31:0] CFG_MASK  = 32'h069E_3F01;
  localparam logic [31:0] CFG_RESET = 32'h0400_0100;

  logic [NUM_PADS-1:0][31:0] cfg_q;
  logic [NUM_PADS-1:0] sync1_q, sync2_q, act_prev_q;
  logic [NUM_PADS-1:0] rx, act, evt, det_off, sci_route;
  logic [NUM_PADS-1:0] ists_q, ien_q, wsts_q, wen_q;
  logic [31:0] rd;

  function automatic logic [ADDR_W-1:0] grp_addr(logic [ADDR_W-1:0] base, int p);
    return base + ADDR_W'(4 * (p / GROUP_SIZE));
  endfunction

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PADS; gp++) begin : g_pad
      assign rx[gp]        = sync2_q[gp] & ~cfg_q[gp][9];
      assign act[gp]       = rx[gp] ^ cfg_q[gp][23];
      assign det_off[gp]   = cfg_q[gp][26:25] == 2'd2;
      assign sci_route[gp] = cfg_q[gp][19];
      assign evt[gp] = det_off[gp]                 ? 1'b0 :
                       (cfg_q[gp][26:25] == 2'd0)  ? act[gp] :
                       (cfg_q[gp][26:25] == 2'd1)  ? (act[gp] & ~act_prev_q[gp]) :
                                                     (act[gp] ^ act_prev_q[gp]);
      assign pad_out[gp] = cfg_q[gp][0];
      assign pad_oe[gp]  = ~cfg_q[gp][8] && (cfg_q[gp][13:10] == 4'd0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q    <= '0;
      sync2_q    <= '0;
      act_prev_q <= '0;
      ists_q     <= '0;
      ien_q      <= '0;
      wsts_q     <= '0;
      wen_q      <= '0;
      irq_o      <= 1'b0;
      wake_o     <= 1'b0;
      for (int p = 0; p < NUM_PADS; p++) cfg_q[p] <= CFG_RESET;
    end else begin
      sync1_q    <= pad_in;
      sync2_q    <= sync1_q;
      act_prev_q <= act;
      irq_o      <= |(ists_q & ien_q);
      wake_o     <= |(wsts_q & wen_q & ~sci_route);
      for (int p = 0; p < NUM_PADS; p++) begin
        if (bus_we && bus_addr == ADDR_W'(p * 8))
          cfg_q[p] <= bus_wdata & CFG_MASK;
        ists_q[p] <= evt[p] | (ists_q[p] &
                     ~(bus_we && bus_addr == grp_addr(ISTS_BASE, p) && bus_wdata[p % GROUP_SIZE]));
        wsts_q[p] <= evt[p] | (wsts_q[p] &
                     ~(bus_we && bus_addr == grp_addr(WSTS_BASE, p) && bus_wdata[p % GROUP_SIZE]));
        if (bus_we && bus_addr == grp_addr(IEN_BASE, p))
          ien_q[p] <= bus_wdata[p % GROUP_SIZE];
        if (bus_we && bus_addr == grp_addr(WEN_BASE, p))
          wen_q[p] <= bus_wdata[p % GROUP_SIZE];
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (bus_addr == ADDR_W'(p * 8)) begin
        rd    = cfg_q[p];
        rd[1] = rx[p];
      end
    end
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int b = 0; b < GROUP_SIZE; b++) begin
        if (g * GROUP_SIZE + b < NUM_PADS) begin
          if (bus_addr == ISTS_BASE + ADDR_W'(4 * g)) rd[b] = ists_q[g * GROUP_SIZE + b];
          if (bus_addr == IEN_BASE  + ADDR_W'(4 * g)) rd[b] = ien_q[g * GROUP_SIZE + b];
          if (bus_addr == WSTS_BASE + ADDR_W'(4 * g)) rd[b] = wsts_q[g * GROUP_SIZE + b];
          if (bus_addr == WEN_BASE  + ADDR_W'(4 * g)) rd[b] = wen_q[g * GROUP_SIZE + b];
        end
      end
    end
  end

  assign bus_rdata = bus_re ? rd : 32'd0;
endmodule

// File: rtl/gpio_evt_ctrl_chk.sv
module gpio_evt_ctrl_chk #(
  parameter int NUM_PADS   = 12,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [GROUP_SIZE-1:0] bus_wlow,
  input logic                  bus_we,
  input logic                  bus_re,
  input logic [31:0]           bus_rdata,
  input logic [NUM_PADS-1:0]   ists_q,
  input logic [NUM_PADS-1:0]   ien_q,
  input logic [NUM_PADS-1:0]   wsts_q,
  input logic [NUM_PADS-1:0]   wen_q,
  input logic [NUM_PADS-1:0]   det_off,
  input logic [NUM_PADS-1:0]   sci_route,
  input logic                  irq_o,
  input logic                  wake_o
);
  localparam int NUM_GROUPS = (NUM_PADS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int LAST_N     = NUM_PADS - (NUM_GROUPS - 1) * GROUP_SIZE;
  localparam logic [31:0] LAST_MASK = (LAST_N >= 32) ? 32'hFFFF_FFFF : ((32'd1 << LAST_N) - 32'd1);
  localparam logic [ADDR_W-1:0] ISTS_BASE = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] IEN_LAST  = ADDR_W'(12'h120 + 4 * (NUM_GROUPS - 1));

  a_r7_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ists_q & ien_q)) |=> irq_o);

  a_r8_irq_low_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |=> !irq_o);

  a_r10_wake_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ((wsts_q & wen_q & ~sci_route) == '0) |=> !wake_o);

  a_r9_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == IEN_LAST) |-> ((bus_rdata & ~LAST_MASK) == 32'd0));

  genvar p;
  generate
    for (p = 0; p < NUM_PADS; p++) begin : g_chk
      a_r2_disabled_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (det_off[p] && !ists_q[p]) |=> !ists_q[p]);
      a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ists_q[p]) |-> $past(bus_we && bus_addr == ISTS_BASE + ADDR_W'(4 * (p / GROUP_SIZE))
                                   && bus_wlow[p % GROUP_SIZE]));
    end
  endgenerate
endmodule

bind gpio_evt_ctrl gpio_evt_ctrl_chk #(
  .NUM_PADS(NUM_PADS), .GROUP_SIZE(GROUP_SIZE), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wlow(bus_wdata[GROUP_SIZE-1:0]),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .ists_q(ists_q), .ien_q(ien_q), .wsts_q(wsts_q), .wen_q(wen_q),
  .det_off(det_off), .sci_route(sci_route), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/gpio_evt_ctrl_tb_top.sv
module gpio_evt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic irq_o, wake_o;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  gpio_evt_ctrl #(.NUM_PADS(NP), .GROUP_SIZE(8), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_o(irq_o), .wake_o(wake_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {evsel[1:0], inv, start, end, exp_after_transition, exp_after_clear}
  localparam logic [6:0] VEC [15] = '{
    7'b00_0_0_1_1_1, 7'b00_0_1_0_1_0, 7'b00_1_0_1_1_0, 7'b00_1_1_0_1_1, 7'b00_1_0_0_1_1,
    7'b01_0_0_1_1_0, 7'b01_0_1_0_0_0, 7'b01_1_1_0_1_0, 7'b01_1_0_1_0_0,
    7'b11_0_0_1_1_0, 7'b11_0_1_0_1_0, 7'b11_1_1_0_1_0,
    7'b10_0_0_1_0_0, 7'b10_1_1_0_0_0, 7'b10_0_1_1_0_0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    wait_clk(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(12'h000, d); chk("R1 cfg reset", d, 32'h0400_0100);
    bus_read(12'h100, d); chk("R1 status reset", d, 0);
    bus_read(12'h120, d); chk("R1 enable reset", d, 0);
    bus_read(12'h160, d); chk("R1 wake enable reset", d, 0);
    chk("R1 irq/wake/oe reset", {irq_o, wake_o, pad_oe}, 0);

    // R2 R6 detection table on pad 0
    for (int i = 0; i < 15; i++) begin
      logic [6:0] v;
      v = VEC[i];
      @(negedge clk) pad_in[0] = v[3];
      bus_write(12'h000, (32'(v[6:5]) << 25) | (32'(v[4]) << 23) | 32'h100);
      wait_clk(6);
      bus_write(12'h100, 32'h1);
      @(negedge clk) pad_in[0] = v[2];
      wait_clk(6);
      bus_read(12'h100, d); chk($sformatf("R2 vec %0d after transition", i), d & 1, 32'(v[1]));
      bus_write(12'h100, 32'h1);
      wait_clk(2);
      bus_read(12'h100, d); chk($sformatf("R6 vec %0d after clear", i), d & 1, 32'(v[0]));
    end
    bus_write(12'h000, 32'h0400_0100);

    // R3 R7 exact timing on pad 3, rising edge
    bus_write(12'h018, 32'h0200_0100);
    wait_clk(4);
    bus_write(12'h100, 32'hFF);
    bus_write(12'h120, 32'h08);
    @(negedge clk);
    bus_addr = 12'h100; bus_re = 1'b1; pad_in[3] = 1'b1;
    wait_clk(2); #1;
    chk("R3 status not yet after two edges", bus_rdata & 32'h8, 0);
    wait_clk(1); #1;
    chk("R3 status set after third edge", bus_rdata & 32'h8, 32'h8);
    chk("R7 irq still low same cycle", 32'(irq_o), 0);
    wait_clk(1); #1;
    chk("R7 irq one clock after pending", 32'(irq_o), 1);
    bus_re = 1'b0;
    // R8 disabling enable drops irq
    bus_write(12'h120, 32'h0);
    wait_clk(1); #1;
    chk("R8 irq low after enable cleared", 32'(irq_o), 0);

    // R3 receiver disable on pad 4
    bus_write(12'h020, 32'h0200_0300);
    @(negedge clk) pad_in[4] = 1'b1;
    wait_clk(5);
    bus_write(12'h100, 32'h10);
    wait_clk(3);
    bus_read(12'h020, d); chk("R3 rx disabled reads 0", d & 32'h2, 0);
    bus_read(12'h100, d); chk("R3 rx disabled no event", d & 32'h10, 0);
    bus_write(12'h020, 32'h0200_0100);
    wait_clk(4);
    bus_read(12'h020, d); chk("R3 rx state reads 1", d & 32'h2, 32'h2);
    bus_read(12'h100, d); chk("R3 receiver enable gives edge", d & 32'h10, 32'h10);

    // R4 output drive
    bus_write(12'h010, 32'h0000_0001);
    #1 chk("R4 drive enabled", {30'd0, pad_out[2], pad_oe[2]}, 32'h3);
    bus_write(12'h010, 32'h0000_0101);
    #1 chk("R4 output disabled", {30'd0, pad_out[2], pad_oe[2]}, 32'h2);
    bus_write(12'h010, 32'h0000_0401);
    #1 chk("R4 non-GPIO mode no drive", {30'd0, pad_out[2], pad_oe[2]}, 32'h2);

    // R5 R9 last pad, partial group
    bus_write(12'h058, 32'h0200_0100);
    wait_clk(4);
    bus_write(12'h104, 32'hFFFF_FFFF);
    @(negedge clk) pad_in[11] = 1'b1;
    wait_clk(5);
    bus_read(12'h104, d); chk("R5 last pad status", d, 32'h8);
    bus_write(12'h104, 32'h0);
    bus_read(12'h104, d); chk("R5 write zero no effect", d, 32'h8);
    bus_write(12'h104, 32'h8);
    bus_read(12'h104, d); chk("R5 write one clears", d, 0);
    bus_write(12'h124, 32'hFFFF_FFFF);
    bus_read(12'h124, d); chk("R9 enable unused bits", d, 32'hF);
    bus_write(12'h164, 32'hFFFF_FFFF);
    bus_read(12'h164, d); chk("R9 wake enable unused bits", d, 32'hF);
    bus_write(12'h124, 32'h0);
    bus_write(12'h164, 32'h0);

    // R10 wake on pad 1
    bus_write(12'h008, 32'h0200_0100);
    wait_clk(4);
    bus_write(12'h140, 32'hFF);
    bus_write(12'h160, 32'h2);
    wait_clk(2); #1;
    chk("R10 wake low before event", 32'(wake_o), 0);
    @(negedge clk) pad_in[1] = 1'b1;
    wait_clk(5); #1;
    chk("R10 wake asserted", 32'(wake_o), 1);
    bus_read(12'h140, d); chk("R10 wake status set", d & 32'h2, 32'h2);
    bus_write(12'h008, 32'h0208_0100);
    wait_clk(2); #1;
    chk("R10 wake suppressed by SCI route", 32'(wake_o), 0);
    bus_read(12'h140, d); chk("R10 wake status kept", d & 32'h2, 32'h2);
    bus_write(12'h140, 32'h2);
    bus_read(12'h140, d); chk("R10 wake status cleared", d & 32'h2, 0);

    // R11 configuration storage mask
    bus_write(12'h038, 32'hFFFF_FFFF);
    bus_read(12'h038, d); chk("R11 stored bits", d, 32'h069E_3F01);
    bus_read(12'h03C, d); chk("R11 second word empty", d, 0);

    done = 1'b1;
    finish_run();
  end
endmodule